// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a link to a small three-wire serial EEPROM. A client hands it one command at a time over a valid/ready request port. Each command carries a command code, an address, write data and a flag that selects the memory's word width. The block builds the serial frame and drives chip select, the serial clock and serial data toward the memory. For reads it samples the memory's data line and returns the word. After each command it drops chip select for a programmable gap. Commands that start an internal program cycle are followed by a status poll. In the poll, chip select is raised again without clocking, and the controller waits for the memory's data line to go high.

Completion is signalled by a one-cycle `rsp_done_o` pulse. A poll that runs out of time raises a one-cycle `rsp_err_o` pulse in its place. The serial clock divisor, the deselect gap and the poll timeout are all parameters.

Top module: `ee3w_host`

## Requirements
- R1: A frame starts with a 1 bit, then a 2-bit opcode, then the address field, all MSB first. The field is 8 bits when `req_wide_i`=1, with the word address in its low 7 bits and a 0 above. It is 9 bits when `req_wide_i`=0, with the byte address in its low 8 bits and a 0 above. Opcodes are read 10, write 01 and erase 11.
- R2: Command codes 3 (unlock), 4 (lock), 5 (erase-all) and 6 (write-all) use opcode 00. The two top bits of the address field are then 11, 00, 10 and 01 respectively, and the rest are 0. Code 7 is framed like lock.
- R3: Each serial-clock phase, high and low, lasts exactly `SK_DIV` clock cycles while chip select is high. Serial data out changes only at the edge where the serial clock falls, so it is stable for the whole high phase.
- R4: For a read (code 0), the first bit sampled from the memory after the address is a dummy and is dropped. The next 16 bits (wide) or 8 bits (narrow) form the word, MSB first. The word is presented on `rsp_rdata_o` with the done pulse; a narrow word sits in bits 7:0 with zeros above.
- R5: For write (code 1) and write-all (code 6), the data word follows the address field MSB first: 16 bits when wide, the low 8 bits when narrow.
- R6: After every frame and after every poll, chip select stays low for at least `GAP_CYC` clock cycles before it rises again. The serial clock is low whenever chip select is low.
- R7: After write, erase, erase-all or write-all, chip select is raised with the serial clock idle. `rsp_done_o` is not given until `mem_sd_i` is seen high (ready); low means busy.
- R8: If `mem_sd_i` stays low for `TIMEOUT_CYC` polling cycles, the command ends with a one-cycle `rsp_err_o` pulse and no `rsp_done_o`. The two pulses never occur together.
- R9: `req_ready_o` is high only while idle, and it drops in the cycle after a request is accepted. `rsp_done_o` lasts exactly one cycle. Unlock, lock and read complete without a poll. After reset, chip select and the serial clock are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Idle, request accepted this cycle if valid |
| req_cmd_i | input | 3 | Command code 0..6 (read, write, erase, unlock, lock, erase-all, write-all) |
| req_addr_i | input | 8 | Word address (wide, low 7 bits used) or byte address (narrow) |
| req_wdata_i | input | 16 | Write data (narrow uses bits 7:0) |
| req_wide_i | input | 1 | 1 = 16-bit word organization, 0 = 8-bit |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | One-cycle busy-poll timeout pulse |
| rsp_rdata_o | output | 16 | Read word, valid with rsp_done_o after a read |
| mem_cs_o | output | 1 | Chip select to the memory |
| mem_sk_o | output | 1 | Serial clock to the memory |
| mem_sd_o | output | 1 | Serial data to the memory |
| mem_sd_i | input | 1 | Serial data / ready status from the memory |

## Verification
The assertions take for granted that `req_valid_i` is only meaningful while idle and that `mem_sd_i` is a clean level, sampled directly without a synchronizer. They also assume the gap counter starts from a saturated value at reset, so the first raise of chip select is legal. The bench drives requests on the falling clock edge, holds them for exactly one cycle, and never changes the organization flag during a command. Its memory model answers the status line combinationally from chip select and its busy counter, so `mem_sd_i` is always settled when sampled.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int AW_WIDE    = 8;
  localparam int AW_NARROW  = 9;
  localparam int DW_NARROW  = 8;
  localparam int HDR_WIDE   = 3 + AW_WIDE;
  localparam int HDR_NARROW = 3 + AW_NARROW;
  localparam int FRAME_W    = HDR_NARROW + DATA_W;

  typedef enum logic [2:0] {
    CMD_READ      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_UNLOCK    = 3'd3,
    CMD_LOCK      = 3'd4,
    CMD_ERASE_ALL = 3'd5,
    CMD_WRITE_ALL = 3'd6
  } cmd_e;

  function automatic logic is_prog(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
  endfunction

  function automatic logic has_data(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
  endfunction

  // serial clock cycles per frame; reads add one for the dummy bit
  function automatic int frame_cycles(cmd_e c, logic wide);
    int hdr, dw;
    hdr = wide ? HDR_WIDE : HDR_NARROW;
    dw  = wide ? DATA_W : DW_NARROW;
    if (c == CMD_READ) return hdr + dw + 1;
    if (has_data(c))   return hdr + dw;
    return hdr;
  endfunction

  // left-aligned frame, zero filled
  function automatic logic [FRAME_W-1:0] build_frame(cmd_e c, logic [ADDR_W-1:0] addr,
                                                     logic [DATA_W-1:0] wd, logic wide);
    logic [1:0]           opc;
    logic [1:0]           sub;
    logic [AW_NARROW-1:0] af;
    logic [DATA_W-1:0]    df;
    af  = wide ? {2'b00, addr[6:0]} : {1'b0, addr};
    df  = has_data(c) ? wd : '0;
    sub = 2'b00;
    case (c)
      CMD_READ:      opc = 2'b10;
      CMD_WRITE:     opc = 2'b01;
      CMD_ERASE:     opc = 2'b11;
      CMD_UNLOCK:    begin opc = 2'b00; sub = 2'b11; end
      CMD_ERASE_ALL: begin opc = 2'b00; sub = 2'b10; end
      CMD_WRITE_ALL: begin opc = 2'b00; sub = 2'b01; end
      default:       begin opc = 2'b00; sub = 2'b00; end
    endcase
    if (opc == 2'b00) af = wide ? {1'b0, sub, 6'b0} : {sub, 7'b0};
    if (wide) return {1'b1, opc, af[AW_WIDE-1:0], df, 1'b0};
    return {1'b1, opc, af, df[DW_NARROW-1:0], 8'b0};
  endfunction
endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
  parameter int DIV = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/ee3w_rx.sv
module ee3w_rx #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sample_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o
);
  logic first_q;
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      first_q <= 1'b1;
    end else if (clr_i) begin
      sr_q    <= '0;
      first_q <= 1'b1;
    end else if (sample_i) begin
      if (first_q) first_q <= 1'b0;  // dummy bit dropped
      else         sr_q    <= {sr_q[DW-2:0], bit_i};
    end
  end

  assign word_o = sr_q;

  // R4
  dummy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && first_q && !clr_i) |=> $stable(word_o));
endmodule

// File: rtl/ee3w_host.sv
module ee3w_host
  import ee3w_pkg::*;
#(
  parameter int SK_DIV      = 13,
  parameter int GAP_CYC     = 13,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_wide_i,
  output logic              rsp_done_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_cs_o,
  output logic              mem_sk_o,
  output logic              mem_sd_o,
  input  logic              mem_sd_i
);
  localparam int IDX_W   = $clog2(FRAME_W + 4);
  localparam int CNT_MAX = (GAP_CYC > TIMEOUT_CYC) ? GAP_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} state_e;

  state_e             state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q, last_q, nsend_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rd_q, prog_q, polled_q, fail_q;
  logic               cs_q, sk_q, done_q, err_q;
  logic               tick, accept, sample;
  cmd_e               cmd;

  assign cmd         = cmd_e'(req_cmd_i);
  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign sample      = (state_q == S_SHIFT) && tick && !sk_q && rd_q && (idx_q >= nsend_q);

  ee3w_tick #(.DIV(SK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_SHIFT),
    .tick_o (tick)
  );

  ee3w_rx #(.DW(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .sample_i (sample),
    .bit_i    (mem_sd_i),
    .word_o   (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      frame_q  <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      nsend_q  <= '0;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      prog_q   <= 1'b0;
      polled_q <= 1'b0;
      fail_q   <= 1'b0;
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          frame_q  <= build_frame(cmd, req_addr_i, req_wdata_i, req_wide_i);
          nsend_q  <= IDX_W'(req_wide_i ? HDR_WIDE : HDR_NARROW);
          last_q   <= IDX_W'(frame_cycles(cmd, req_wide_i) - 1);
          rd_q     <= (cmd == CMD_READ);
          prog_q   <= is_prog(cmd);
          polled_q <= 1'b0;
          fail_q   <= 1'b0;
          idx_q    <= '0;
          cs_q     <= 1'b1;
          sk_q     <= 1'b0;
          state_q  <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
          end else begin
            sk_q    <= 1'b0;
            frame_q <= frame_q << 1;  // data moves with the falling edge
            if (idx_q == last_q) begin
              cs_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= S_GAP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
            cnt_q <= '0;
            if (prog_q && !polled_q) begin
              polled_q <= 1'b1;
              cs_q     <= 1'b1;
              state_q  <= S_POLL;
            end else begin
              done_q  <= !fail_q;
              err_q   <= fail_q;
              state_q <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_POLL: begin
          if (mem_sd_i) begin
            cs_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_GAP;
          end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
            fail_q  <= 1'b1;
            cs_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_cs_o   = cs_q;
  assign mem_sk_o   = sk_q;
  assign mem_sd_o   = cs_q & frame_q[FRAME_W-1];
  assign rsp_done_o = done_q;
  assign rsp_err_o  = err_q;

  // deselect run length, saturating; starts saturated so reset counts as idle
  logic [GAP_W-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             low_run_q <= GAP_W'(GAP_CYC);
    else if (cs_q)                           low_run_q <= '0;
    else if (low_run_q != GAP_W'(GAP_CYC))   low_run_q <= low_run_q + 1'b1;
  end

  // R6
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> (low_run_q == GAP_W'(GAP_CYC)));
  // R6
  sk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_o |-> !mem_sk_o);
  // R3
  sd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sk_o && $past(mem_sk_o)) |-> $stable(mem_sd_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  // R8
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_done_o && rsp_err_o));
  // R9
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R7
  poll_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL) |-> (mem_cs_o && !mem_sk_o));
endmodule

// File: tb/ee3w_host_bench.sv
module ee3w_host_bench;
  localparam int SK_DIV = 13;
  localparam int GAP    = 13;
  localparam int TMO    = 5000;
  localparam int BUSY   = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_wide = 1'b1;
  logic        done, err;
  logic [15:0] rdata;
  logic        cs_o, sk_o, sd_o, sd_i;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ee3w_host #(.SK_DIV(SK_DIV), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) u_ee3w_host (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_wide_i(req_wide),
    .rsp_done_o(done), .rsp_err_o(err), .rsp_rdata_o(rdata),
    .mem_cs_o(cs_o), .mem_sk_o(sk_o), .mem_sd_o(sd_o), .mem_sd_i(sd_i)
  );

  // ---------------- memory model ----------------
  logic [15:0] m_mem [0:127];
  bit          m_wide = 1'b1;
  bit          m_en, m_started, m_reading, m_stuck = 1'b0;
  bit          m_sk_q, m_cs_q, m_do;
  int          m_cnt, m_busy, m_prog;
  logic [31:0] m_sr;
  logic [15:0] m_osr;

  assign sd_i = cs_o ? (m_reading ? m_do : ((m_busy != 0 || m_stuck) ? 1'b0 : 1'b1)) : 1'b1;

  task automatic m_put(input logic [8:0] a, input logic [15:0] d);
    if (m_wide) m_mem[a[6:0]] = d;
    else if (a[0]) m_mem[a[7:1]][15:8] = d[7:0];
    else m_mem[a[7:1]][7:0] = d[7:0];
  endtask

  always @(posedge clk) begin
    logic [31:0] nsr, hdr;
    logic [15:0] dat;
    logic [8:0]  a, amask;
    logic [1:0]  opc, top2;
    int ab, db;
    bit full, shrt;
    ab    = m_wide ? 8 : 9;
    db    = m_wide ? 16 : 8;
    amask = m_wide ? 9'h07F : 9'h0FF;
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m_mem[i] = 16'hFFFF;
      m_en <= 0; m_started <= 0; m_reading <= 0; m_sk_q <= 0; m_cs_q <= 0;
      m_do <= 0; m_cnt <= 0; m_busy <= 0; m_prog = 0; m_sr <= 0; m_osr <= 0;
    end else begin
      if (m_busy > 0) m_busy <= m_busy - 1;
      m_sk_q <= sk_o;
      m_cs_q <= cs_o;
      if (cs_o && sk_o && !m_sk_q) begin
        if (!m_started) begin
          if (sd_o) begin m_started <= 1; m_cnt <= 0; m_sr <= 0; end
        end else begin
          nsr = {m_sr[30:0], sd_o};
          m_sr  <= nsr;
          m_cnt <= m_cnt + 1;
          if (m_reading) begin
            m_do  <= m_osr[15];
            m_osr <= {m_osr[14:0], 1'b0};
          end else if (m_cnt + 1 == 2 + ab && 2'(nsr >> ab) == 2'b10) begin
            a = nsr[8:0] & amask;
            m_reading <= 1;
            m_do      <= 0;
            if (m_wide) m_osr <= m_mem[a[6:0]];
            else m_osr <= {a[0] ? m_mem[a[7:1]][15:8] : m_mem[a[7:1]][7:0], 8'h00};
          end
        end
      end
      if (!cs_o && m_cs_q) begin
        full = m_started && (m_cnt == 2 + ab + db);
        shrt = m_started && (m_cnt == 2 + ab);
        hdr  = full ? (m_sr >> db) : m_sr;
        dat  = 16'(m_sr) & (m_wide ? 16'hFFFF : 16'h00FF);
        opc  = 2'(hdr >> ab);
        top2 = 2'(hdr >> (ab - 2));
        a    = 9'(hdr) & amask;
        if (shrt && opc == 2'b00 && top2 == 2'b11) m_en <= 1;
        if (shrt && opc == 2'b00 && top2 == 2'b00) m_en <= 0;
        if (m_en) begin
          if (full && opc == 2'b01) begin
            m_put(a, dat); m_busy <= BUSY; m_prog++;
          end else if (shrt && opc == 2'b11) begin
            m_put(a, 16'hFFFF); m_busy <= BUSY; m_prog++;
          end else if (shrt && opc == 2'b00 && top2 == 2'b10) begin
            for (int i = 0; i < 128; i++) m_mem[i] = 16'hFFFF;
            m_busy <= BUSY; m_prog++;
          end else if (full && opc == 2'b00 && top2 == 2'b01) begin
            for (int i = 0; i < 128; i++) m_mem[i] = m_wide ? dat : {dat[7:0], dat[7:0]};
            m_busy <= BUSY; m_prog++;
          end
        end
        m_started <= 0; m_reading <= 0; m_cnt <= 0;
      end
    end
  end

  // ---------------- line monitors ----------------
  int low_run = 1000, hi_run = 0, lo_run = 0;
  int gap_bad = 0, sk_bad = 0, sd_bad = 0, ph_bad = 0;
  bit cs_prev = 0, sk_prev = 0, sd_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_o) low_run++;
      else begin
        if (!cs_prev && low_run < GAP) gap_bad++;
        low_run = 0;
      end
      if (sk_o && !cs_o) sk_bad++;
      if (sk_o && sk_prev && sd_o != sd_prev) sd_bad++;
      if (sk_o) begin
        hi_run++;
        if (!sk_prev && lo_run < SK_DIV) ph_bad++;
        lo_run = 0;
      end else begin
        if (sk_prev && hi_run != SK_DIV) ph_bad++;
        hi_run = 0;
        if (cs_o) lo_run++; else lo_run = 0;
      end
    end
    cs_prev = cs_o; sk_prev = sk_o; sd_prev = sd_o;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] cmd, input logic [7:0] addr, input logic [15:0] wd,
                        input bit wide, output logic [15:0] rd, output bit gdone, output bit gerr);
    int n;
    m_wide = wide;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = addr; req_wdata = wd; req_wide = wide;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9", "ready after accept", 32'(req_ready), 0);
    n = 0;
    while (!done && !err && n < 20000) begin @(negedge clk); n++; end
    gdone = done; gerr = err; rd = rdata;
    @(negedge clk);
    chk(!done && !err, "R9", "completion pulse width", {done, err}, 0);
  endtask

  task automatic rd_chk(input logic [7:0] addr, input bit wide, input logic [15:0] exp,
                        input string req);
    logic [15:0] rd; bit gd, ge;
    do_cmd(3'd0, addr, 16'h0, wide, rd, gd, ge);
    chk(gd && !ge, req, "read done", {gd, ge}, 2'b10);
    chk(rd == exp, req, "read word", rd, exp);
  endtask

  task automatic prog_chk(input logic [2:0] cmd, input logic [7:0] addr, input logic [15:0] wd,
                          input bit wide, input int exp_prog, input string req);
    logic [15:0] rd; bit gd, ge; int p0;
    p0 = m_prog;
    do_cmd(cmd, addr, wd, wide, rd, gd, ge);
    chk(gd && !ge, req, "command done", {gd, ge}, 2'b10);
    chk(m_prog - p0 == exp_prog, req, "program cycles started", m_prog - p0, exp_prog);
    chk(m_busy == 0, "R7", "done only after ready", m_busy, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(req_ready == 1, "R9", "reset ready", req_ready, 1);
    chk(cs_o == 0 && sk_o == 0, "R9", "reset lines", {cs_o, sk_o}, 0);
    chk(done == 0 && err == 0, "R9", "reset pulses", {done, err}, 0);
  endtask

  task automatic t_locked_write;
    prog_chk(3'd1, 8'd3, 16'h1111, 1'b1, 0, "R2");
    rd_chk(8'd3, 1'b1, 16'hFFFF, "R2");
  endtask

  task automatic t_unlock;
    prog_chk(3'd3, 8'd0, 16'h0, 1'b1, 0, "R9");
  endtask

  task automatic t_wide_rw;
    prog_chk(3'd1, 8'd5, 16'hA5C3, 1'b1, 1, "R5");
    rd_chk(8'd5, 1'b1, 16'hA5C3, "R4");
    prog_chk(3'd1, 8'd127, 16'h8001, 1'b1, 1, "R1");
    rd_chk(8'd127, 1'b1, 16'h8001, "R1");
  endtask

  task automatic t_narrow_rw;
    prog_chk(3'd1, 8'h81, 16'h003C, 1'b0, 1, "R5");
    rd_chk(8'h81, 1'b0, 16'h003C, "R1");
    rd_chk(8'h80, 1'b0, 16'h00FF, "R4");
    rd_chk(8'h40, 1'b1, 16'h3CFF, "R1");
  endtask

  task automatic t_erase;
    prog_chk(3'd2, 8'd5, 16'h0, 1'b1, 1, "R1");
    rd_chk(8'd5, 1'b1, 16'hFFFF, "R1");
  endtask

  task automatic t_write_all;
    prog_chk(3'd6, 8'd0, 16'h1234, 1'b1, 1, "R2");
    rd_chk(8'h10, 1'b1, 16'h1234, "R2");
    rd_chk(8'h7F, 1'b1, 16'h1234, "R2");
  endtask

  task automatic t_erase_all;
    prog_chk(3'd5, 8'd0, 16'h0, 1'b1, 1, "R2");
    rd_chk(8'h10, 1'b1, 16'hFFFF, "R2");
  endtask

  task automatic t_lock;
    prog_chk(3'd4, 8'd0, 16'h0, 1'b1, 0, "R2");
    prog_chk(3'd1, 8'd2, 16'hBEEF, 1'b1, 0, "R2");
    rd_chk(8'd2, 1'b1, 16'hFFFF, "R2");
  endtask

  task automatic t_timeout;
    logic [15:0] rd; bit gd, ge;
    prog_chk(3'd3, 8'd0, 16'h0, 1'b1, 0, "R9");
    m_stuck = 1;
    do_cmd(3'd2, 8'd1, 16'h0, 1'b1, rd, gd, ge);
    chk(ge == 1, "R8", "timeout error pulse", ge, 1);
    chk(gd == 0, "R8", "no done on timeout", gd, 0);
    m_stuck = 0;
    prog_chk(3'd1, 8'd9, 16'h5A5A, 1'b1, 1, "R7");
    rd_chk(8'd9, 1'b1, 16'h5A5A, "R7");
  endtask

  task automatic t_line_timing;
    chk(ph_bad == 0, "R3", "serial clock phase length", ph_bad, 0);
    chk(sd_bad == 0, "R3", "data change while clock high", sd_bad, 0);
    chk(gap_bad == 0, "R6", "deselect gap", gap_bad, 0);
    chk(sk_bad == 0, "R6", "clock while deselected", sk_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_locked_write();
    t_unlock();
    t_wide_rw();
    t_narrow_rw();
    t_erase();
    t_write_all();
    t_erase_all();
    t_lock();
    t_timeout();
    t_line_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule